// File: doc/BRIEF.md
# ATA Security Lock Controller

This block tracks the password security state of a storage device: security off, locked, unlocked and frozen. It decides, for each security command, whether the command is accepted or aborted. The surrounding controller stores the passwords and moves the 512-byte command payloads. It hands this block an opcode, the outcome of the password comparison, the identifier kind (master or user) and the stored security level. The block answers one cycle later with an accept or abort flag. When a secure erase is granted, it also raises a one-cycle strobe that starts the erase.

The block limits failed unlock attempts with a counter. Once the counter is exhausted, unlock and erase stay refused until the next reset. An erase is only granted when the command immediately before it was an accepted erase preparation. Freezing blocks every change to the security state until reset. A status nibble gives the enabled, locked, frozen and attempts-expired flags for the identify response.

Top module: `sec_lock_ctrl`

## Requirements
- R1: While `rst_n` is low the attempt counter loads `TRIES` (default 5). The state becomes locked with security enabled if `boot_enabled` is 1, otherwise security off. No response is issued during or right after reset.
- R2: A failed user unlock (`pw_match`=0) while locked decrements the counter. At zero the expired flag is set, and unlock and erase-unit abort even with a matching password until reset.
- R3: Set-password (op 1) is accepted in the security-off or unlocked state and leaves the device unlocked with security enabled. It aborts when locked or frozen.
- R4: Unlock (op 2) while locked with a matching password unlocks the device. In the unlocked state it is accepted only with a match, without touching the counter. It aborts in any other state.
- R5: A master-identifier unlock at maximum level (`id_master`=1, `level_max`=1) is rejected without decrementing the counter. At high level (`level_max`=0) it is decided by the compare result.
- R6: Disable-password (op 3) with a match in the unlocked state turns security off. Otherwise it aborts.
- R7: Freeze (op 6) from security-off or unlocked enters the frozen state. A repeated freeze while frozen is accepted. While frozen, ops 1 to 5 abort, and only reset leaves frozen. Freeze aborts while locked.
- R8: Erase-unit (op 5) aborts unless the previous command was an accepted erase-prepare (op 4). Any other command in between, including op 0, clears that condition.
- R9: A prepared, unexpired, unfrozen erase-unit with a match is accepted, pulses `erase_start` for one cycle together with the response, and turns security off. A mismatch aborts with no pulse.
- R10: Every cycle with `cmd_valid`=1 gets `rsp_valid`=1 on the following cycle with `rsp_abort` as the verdict. Ops 0 and 7 are accepted and change no state.
- R11: `sec_status` bit 0 is enabled, bit 1 locked, bit 2 frozen, bit 3 attempts expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on / hardware reset |
| boot_enabled | input | 1 | A password was stored before reset; the device wakes up locked |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code (0 other, 1 set, 2 unlock, 3 disable, 4 prepare, 5 erase, 6 freeze, 7 other) |
| pw_match | input | 1 | Supplied password matched the selected stored one |
| id_master | input | 1 | Identifier selects the master password |
| level_max | input | 1 | Stored security level is maximum (0 = high) |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_abort | output | 1 | Command aborted (1) or accepted (0) |
| erase_start | output | 1 | One-cycle erase launch strobe |
| sec_status | output | 4 | {expired, frozen, locked, enabled} |

## Verification
On every cycle, the assertions check these rules:
- the attempt counter never increases;
- frozen never leaves without reset;
- exhausted or unprepared erases and unlocks are always refused;
- a master unlock at maximum level is refused;
- each command gets exactly one response, one cycle later;
- an erase strobe only comes with an accepted response.

Only the bench's scenarios can show the exact decrement count to expiry and the full state walks. These include locked, unlocked, disabled, frozen and back through reset, and the clearing of a preparation by an intervening command. A long pseudo-random command stream compared against an independent model covers the combinations of opcode, compare result, identifier and level in every reachable state.

// File: rtl/sec_lock_pkg.sv
package sec_lock_pkg;

  typedef enum logic [2:0] {
    OP_OTHER  = 3'd0,
    OP_SETPW  = 3'd1,
    OP_UNLOCK = 3'd2,
    OP_DISPW  = 3'd3,
    OP_PREP   = 3'd4,
    OP_ERASE  = 3'd5,
    OP_FREEZE = 3'd6,
    OP_SPARE  = 3'd7
  } sec_op_e;

  typedef enum logic [2:0] {
    ST_OPEN      = 3'd0,
    ST_LOCKED    = 3'd1,
    ST_UNLOCKED  = 3'd2,
    ST_FRZ_OPEN  = 3'd3,
    ST_FRZ_ARMED = 3'd4
  } sec_st_e;

  typedef struct packed {
    logic    abort;
    logic    dec;
    logic    erase;
    sec_st_e nxt;
  } sec_dec_t;

  function automatic logic st_frozen(sec_st_e st);
    return (st == ST_FRZ_OPEN) || (st == ST_FRZ_ARMED);
  endfunction

  function automatic logic st_enabled(sec_st_e st);
    return (st == ST_LOCKED) || (st == ST_UNLOCKED) || (st == ST_FRZ_ARMED);
  endfunction

  // Verdict and next state for one command in one state.
  function automatic sec_dec_t sec_decide(sec_st_e st, sec_op_e op, logic match,
                                          logic master, logic lvl_max,
                                          logic expired, logic prep);
    sec_dec_t d;
    d.abort = 1'b0;
    d.dec   = 1'b0;
    d.erase = 1'b0;
    d.nxt   = st;
    case (op)
      OP_SETPW: begin
        if (st == ST_OPEN || st == ST_UNLOCKED) d.nxt = ST_UNLOCKED;
        else d.abort = 1'b1;
      end
      OP_UNLOCK: begin
        if (st == ST_LOCKED) begin
          if (expired) d.abort = 1'b1;
          else if (master && lvl_max) d.abort = 1'b1;
          else if (match) d.nxt = ST_UNLOCKED;
          else begin
            d.abort = 1'b1;
            d.dec   = 1'b1;
          end
        end else if (st == ST_UNLOCKED) begin
          d.abort = !match;
        end else begin
          d.abort = 1'b1;
        end
      end
      OP_DISPW: begin
        if (st == ST_UNLOCKED && match) d.nxt = ST_OPEN;
        else d.abort = 1'b1;
      end
      OP_PREP: d.abort = st_frozen(st);
      OP_ERASE: begin
        if (st_frozen(st) || expired || !prep || !match) d.abort = 1'b1;
        else begin
          d.erase = 1'b1;
          d.nxt   = ST_OPEN;
        end
      end
      OP_FREEZE: begin
        if (st == ST_LOCKED) d.abort = 1'b1;
        else if (st == ST_OPEN) d.nxt = ST_FRZ_OPEN;
        else if (st == ST_UNLOCKED) d.nxt = ST_FRZ_ARMED;
      end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sec_try_cnt.sv
module sec_try_cnt #(
  parameter int TRIES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_i,
  output logic expired_o
);
  localparam int CW = $clog2(TRIES + 1);
  localparam logic [CW-1:0] START = CW'(TRIES);

  logic [CW-1:0] cnt_q;
  logic          at_zero;

  assign at_zero   = (cnt_q == '0);
  assign expired_o = at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= START;
    else if (dec_i && !at_zero) cnt_q <= cnt_q - 1'b1;
  end

  p_count_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q <= $past(cnt_q));

  p_zero_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> expired_o);

endmodule

// File: rtl/sec_prep_trk.sv
module sec_prep_trk
  import sec_lock_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  sec_op_e op,
  input  logic    abort,
  output logic    prep_o
);
  logic prep_q;
  assign prep_o = prep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prep_q <= 1'b0;
    else if (cmd_valid) prep_q <= (op == OP_PREP) && !abort;
  end

  p_prep_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op != OP_PREP |=> !prep_q);

endmodule

// File: rtl/sec_state_fsm.sv
module sec_state_fsm
  import sec_lock_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    boot_enabled,
  input  logic    cmd_valid,
  input  sec_op_e op,
  input  logic    match,
  input  logic    master,
  input  logic    lvl_max,
  input  logic    expired,
  input  logic    prep,
  output sec_st_e state_o,
  output logic    dec_o,
  output logic    abort_now_o,
  output logic    rsp_valid_o,
  output logic    rsp_abort_o,
  output logic    erase_o
);
  sec_st_e  state_q;
  sec_dec_t d;
  logic     rsp_valid_q, rsp_abort_q, erase_q;

  always_comb d = sec_decide(state_q, op, match, master, lvl_max, expired, prep);

  assign dec_o       = cmd_valid && d.dec;
  assign abort_now_o = d.abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= boot_enabled ? ST_LOCKED : ST_OPEN;
      rsp_valid_q <= 1'b0;
      rsp_abort_q <= 1'b0;
      erase_q     <= 1'b0;
    end else begin
      rsp_valid_q <= cmd_valid;
      rsp_abort_q <= cmd_valid && d.abort;
      erase_q     <= cmd_valid && d.erase;
      if (cmd_valid) state_q <= d.nxt;
    end
  end

  assign state_o     = state_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_abort_o = rsp_abort_q;
  assign erase_o     = erase_q;

  p_frozen_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_frozen(state_q) |=> st_frozen(state_q));

  p_master_max_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_UNLOCK && state_q == ST_LOCKED && master && lvl_max
    |=> rsp_abort_q && state_q == ST_LOCKED);

  p_erase_needs_prep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_ERASE && !prep |=> rsp_abort_q && !erase_q);

  p_expired_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && expired && (op == OP_UNLOCK || op == OP_ERASE) |=> rsp_abort_q);

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid_q);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid_q && !erase_q);

  p_erase_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_q |-> rsp_valid_q && !rsp_abort_q && state_q == ST_OPEN);

endmodule

// File: rtl/sec_lock_ctrl.sv
module sec_lock_ctrl
  import sec_lock_pkg::*;
#(
  parameter int TRIES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_enabled,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       pw_match,
  input  logic       id_master,
  input  logic       level_max,
  output logic       rsp_valid,
  output logic       rsp_abort,
  output logic       erase_start,
  output logic [3:0] sec_status
);
  sec_op_e op;
  sec_st_e state;
  logic    expired, prep, dec, abort_now;

  assign op = sec_op_e'(cmd_op);

  sec_try_cnt #(.TRIES(TRIES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_i     (dec),
    .expired_o (expired)
  );

  sec_prep_trk u_prep (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .op        (op),
    .abort     (abort_now),
    .prep_o    (prep)
  );

  sec_state_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_enabled (boot_enabled),
    .cmd_valid    (cmd_valid),
    .op           (op),
    .match        (pw_match),
    .master       (id_master),
    .lvl_max      (level_max),
    .expired      (expired),
    .prep         (prep),
    .state_o      (state),
    .dec_o        (dec),
    .abort_now_o  (abort_now),
    .rsp_valid_o  (rsp_valid),
    .rsp_abort_o  (rsp_abort),
    .erase_o      (erase_start)
  );

  // R11: status nibble
  assign sec_status = {expired, st_frozen(state), state == ST_LOCKED, st_enabled(state)};

  p_status_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sec_status[1], sec_status[2]}));

endmodule

// File: tb/tb_sec_lock_ctrl.sv
module tb_sec_lock_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TRIES = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_enabled = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic pw_match = 1'b0, id_master = 1'b0, level_max = 1'b0;
  logic rsp_valid, rsp_abort, erase_start;
  logic [3:0] sec_status;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model: 0 off, 1 locked, 2 unlocked, 3 frozen-off, 4 frozen-enabled
  int m_st = 0;
  int m_cnt = TRIES;
  bit m_prep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_lock_ctrl #(.TRIES(TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .boot_enabled(boot_enabled),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pw_match(pw_match),
    .id_master(id_master), .level_max(level_max),
    .rsp_valid(rsp_valid), .rsp_abort(rsp_abort),
    .erase_start(erase_start), .sec_status(sec_status)
  );

  function automatic logic [3:0] m_status();
    logic [3:0] s;
    s[0] = (m_st == 1) || (m_st == 2) || (m_st == 4);
    s[1] = (m_st == 1);
    s[2] = (m_st >= 3);
    s[3] = (m_cnt == 0);
    return s;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R8";
      5: return "R9";
      6: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit boot);
    @(negedge clk);
    rst_n = 1'b0;
    boot_enabled = boot;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_st = boot ? 1 : 0;
    m_cnt = TRIES;
    m_prep = 0;
    check("R1", "status after reset", sec_status, m_status());
    check("R1", "no response after reset", rsp_valid, 0);
  endtask

  // Called at a negedge; returns at the following negedge after checking.
  task automatic issue(input int op, input bit m, input bit ms, input bit lv, input string req);
    bit ab, er, frz;
    ab = 0; er = 0;
    frz = (m_st >= 3);
    if (op == 1) begin
      if (m_st == 0 || m_st == 2) m_st = 2; else ab = 1;
    end else if (op == 2) begin
      if (m_st == 1) begin
        if (m_cnt == 0) ab = 1;
        else if (ms && lv) ab = 1;
        else if (m) m_st = 2;
        else begin ab = 1; m_cnt = m_cnt - 1; end
      end else if (m_st == 2) ab = !m;
      else ab = 1;
    end else if (op == 3) begin
      if (m_st == 2 && m) m_st = 0; else ab = 1;
    end else if (op == 4) begin
      ab = frz;
    end else if (op == 5) begin
      if (frz || m_cnt == 0 || !m_prep || !m) ab = 1;
      else begin er = 1; m_st = 0; end
    end else if (op == 6) begin
      if (m_st == 1) ab = 1;
      else if (m_st == 0) m_st = 3;
      else if (m_st == 2) m_st = 4;
    end
    m_prep = (op == 4) && !ab;

    cmd_op = 3'(op);
    pw_match = m; id_master = ms; level_max = lv;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(req, "rsp_valid", rsp_valid, 1);
    check(req, "rsp_abort", rsp_abort, ab);
    check(req, "erase_start", erase_start, er);
    check(req, "status", sec_status, m_status());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    bit prev_prep;
    int op;
    // R1: both reset flavours
    do_reset(1'b0);
    check("R11", "off status literal", sec_status, 4'b0000);
    do_reset(1'b1);
    check("R11", "locked status literal", sec_status, 4'b0011);

    // R2 / R5: attempts run out
    for (int i = 0; i < TRIES - 1; i++) issue(2, 0, 0, 0, "R2");
    issue(2, 1, 1, 1, "R5");          // master at max level: refused, no decrement
    issue(2, 0, 1, 1, "R5");
    check("R5", "not yet expired", sec_status[3], 0);
    issue(2, 0, 0, 0, "R2");
    check("R2", "expired flag", sec_status, 4'b1011);
    issue(2, 1, 0, 0, "R2");
    issue(4, 1, 0, 0, "R2");
    issue(5, 1, 0, 0, "R2");
    issue(6, 1, 0, 0, "R7");          // freeze while locked aborts
    do_reset(1'b1);
    check("R2", "counter restored", sec_status[3], 0);

    // R5 high level master, R6, R3, R7
    issue(2, 1, 1, 0, "R5");
    check("R4", "unlocked status", sec_status, 4'b0001);
    issue(2, 0, 0, 0, "R4");          // mismatch in unlocked: abort, no count
    issue(3, 0, 0, 0, "R6");
    issue(3, 1, 0, 0, "R6");
    check("R6", "security off", sec_status, 4'b0000);
    issue(1, 0, 0, 0, "R3");
    check("R3", "enabled", sec_status, 4'b0001);
    issue(6, 0, 0, 0, "R7");
    check("R11", "frozen enabled literal", sec_status, 4'b0101);
    issue(6, 0, 0, 0, "R7");
    for (int o = 1; o <= 5; o++) issue(o, 1, 0, 0, "R7");
    issue(0, 0, 0, 0, "R10");
    issue(7, 1, 1, 1, "R10");
    @(negedge clk);
    check("R10", "idle no response", rsp_valid, 0);
    check("R7", "still frozen", sec_status[2], 1);
    do_reset(1'b0);
    issue(6, 0, 0, 0, "R7");
    check("R7", "frozen off", sec_status, 4'b0100);
    do_reset(1'b0);

    // R8 / R9
    issue(5, 1, 0, 0, "R8");
    issue(4, 0, 0, 0, "R8");
    issue(0, 1, 0, 0, "R8");
    issue(5, 1, 0, 0, "R8");
    issue(4, 0, 0, 0, "R9");
    issue(5, 0, 0, 0, "R9");
    issue(5, 1, 0, 0, "R8");          // prepare consumed by the failed erase
    issue(1, 0, 0, 0, "R3");
    issue(4, 0, 0, 0, "R9");
    issue(5, 1, 1, 1, "R9");
    check("R9", "off after erase", sec_status, 4'b0000);
    @(negedge clk);
    check("R9", "strobe one cycle", erase_start, 0);

    // Pseudo-random sweep against the model
    lf = 16'hACE1;
    prev_prep = 0;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (k % 300 == 0) do_reset(lf[7]);
      op = (prev_prep && lf[3]) ? 5 : int'(lf[2:0]);
      issue(op, lf[4] | lf[8], lf[5], lf[6], req_of(op));
      prev_prep = (op == 4);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule